// File: doc/BRIEF.md
# Parallel-Word Bit-Slip Aligner

This block moves the bit alignment of a stream of parallel words, one word per clock. It has a receive path and a transmit path. Each path joins the word arriving now with the word before it into a double-width window. It then takes one word-wide slice of that window, starting at its current bit offset, and registers the slice as its output.

On the receive side the offset is not programmed. A slip-request input moves it forward by one bit on each rising edge. After the largest offset it wraps back to zero. The logic that decides when alignment is wrong drives the request, and that logic is outside this block. Rising edges must be spaced at least `MIN_GAP` cycles apart. An edge that comes sooner is dropped and sets a sticky error flag.

On the transmit side a multi-bit input sets the slip amount directly. The block samples it once per word. A new amount shapes the output from the following word onward. Both paths report the offset they are using.

Top module: `word_slip_aligner`

## Requirements
- R1: A rising edge of `rx_slip_req` sampled at a clock edge raises `rx_offset` by exactly one at that same clock edge.
- R2: While `rx_slip_req` stays high after its rising edge, `rx_offset` does not change.
- R3: A rising edge that comes fewer than `MIN_GAP` (default 20) cycles after the last accepted edge leaves `rx_offset` unchanged. It also sets `rx_slip_err`, which stays set until reset. An edge that comes exactly `MIN_GAP` cycles later is accepted.
- R4: After each clock edge, `rx_out` equals bits [k+W-1:k] of the 2W-bit value {rx_data, previous rx_data}. Here k is the `rx_offset` held just before that edge and the current word sits in the upper half. With k = 0, `rx_out` is the previous input word.
- R5: An accepted edge at offset W-1 sets `rx_offset` to 0. W accepted edges after reset return it to 0.
- R6: After each clock edge, `tx_out` equals bits [a+W-1:a] of {tx_data, previous tx_data}. Here a is the `tx_offset` held just before that edge.
- R7: `tx_offset` takes the value of `tx_slip_amt` sampled at the previous clock edge. A change of amount therefore first affects the output word produced one word later.
- R8: During and after reset (`rst_n` low, synchronous), both offsets, both outputs, the error flag and the stored previous words are 0. The first rising edge after reset is accepted with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | W | Receive word in |
| rx_slip_req | input | 1 | Slip request; each rising edge adds one bit of offset |
| rx_out | output | W | Registered, realigned receive word |
| rx_offset | output | $clog2(W) | Current receive bit offset |
| rx_slip_err | output | 1 | Sticky flag: a request edge came too soon |
| tx_data | input | W | Transmit word in |
| tx_slip_amt | input | $clog2(W) | Programmed transmit slip amount |
| tx_out | output | W | Registered, realigned transmit word |
| tx_offset | output | $clog2(W) | Transmit slip amount in use |

## Verification
The assertions assume that W is a power of two, so every value of an offset field is a legal offset. They also assume that `rst_n` is held low for at least one clock edge before checking starts. A too-early request edge is treated as a legal input whose effect is checked, not as a violation. The stimulus changes every input half a cycle away from the sampling edge. It spaces sweep requests exactly `MIN_GAP` cycles apart. It places deliberate early edges and long held-high requests only inside the scenarios that check them.

// File: rtl/word_slip_aligner.sv
module word_slip_aligner #(
  parameter int W       = 64,
  parameter int MIN_GAP = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         rx_data,
  input  logic                 rx_slip_req,
  output logic [W-1:0]         rx_out,
  output logic [$clog2(W)-1:0] rx_offset,
  output logic                 rx_slip_err,
  input  logic [W-1:0]         tx_data,
  input  logic [$clog2(W)-1:0] tx_slip_amt,
  output logic [W-1:0]         tx_out,
  output logic [$clog2(W)-1:0] tx_offset
);
  localparam int OW = $clog2(W);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [OW-1:0] LAST = OW'(W - 1);
  localparam logic [GW-1:0] GAP  = GW'(MIN_GAP);

  logic [W-1:0]   rx_prev, tx_prev;
  logic           req_q;
  logic [GW-1:0]  gap_cnt;
  logic [2*W-1:0] rx_win, tx_win;
  logic           rise, take;

  assign rise   = rx_slip_req & ~req_q;
  assign take   = rise & (gap_cnt >= GAP);
  assign rx_win = {rx_data, rx_prev} >> rx_offset;
  assign tx_win = {tx_data, tx_prev} >> tx_offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      gap_cnt     <= GAP;
      rx_offset   <= '0;
      rx_slip_err <= 1'b0;
      rx_prev     <= '0;
      rx_out      <= '0;
    end else begin
      req_q   <= rx_slip_req;
      rx_prev <= rx_data;
      rx_out  <= rx_win[W-1:0];
      if (take) begin
        rx_offset <= (rx_offset == LAST) ? '0 : rx_offset + 1'b1;
        gap_cnt   <= GW'(1);
      end else if (gap_cnt < GAP) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (rise && !take) rx_slip_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev   <= '0;
      tx_offset <= '0;
      tx_out    <= '0;
    end else begin
      tx_prev   <= tx_data;
      tx_offset <= tx_slip_amt;
      tx_out    <= tx_win[W-1:0];
    end
  end

  p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && gap_cnt >= GAP && rx_offset != LAST) |=> rx_offset == $past(rx_offset) + 1'b1);

  p_level_no_slip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && rx_slip_req) |=> $stable(rx_offset));

  p_early_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && gap_cnt < GAP) |=> (rx_slip_err && $stable(rx_offset)));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slip_err |=> rx_slip_err);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && gap_cnt >= GAP && rx_offset == LAST) |=> rx_offset == '0);

  p_tx_next_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> tx_offset == $past(tx_slip_amt));
endmodule

// File: tb/test_word_slip_aligner.sv
module test_word_slip_aligner;
  localparam int W = 64;
  localparam int OW = 6;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] rx_data = '0, tx_data = '0, rx_out, tx_out;
  logic rx_slip_req = 1'b0, rx_slip_err;
  logic [OW-1:0] rx_offset, tx_offset, tx_slip_amt = '0;

  word_slip_aligner #(.W(W), .MIN_GAP(GAP)) i_word_slip_aligner (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_slip_req(rx_slip_req),
    .rx_out(rx_out), .rx_offset(rx_offset), .rx_slip_err(rx_slip_err),
    .tx_data(tx_data), .tx_slip_amt(tx_slip_amt), .tx_out(tx_out), .tx_offset(tx_offset));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, seq = 0;
  logic [W-1:0] m_rx_prev, m_tx_prev;
  logic [OW-1:0] m_off, m_tamt;
  logic m_req, m_err;
  int m_gap;

  function automatic logic [W-1:0] word_of(input int n);
    return {32'(n) * 32'h9E3779B1, ~(32'(n) * 32'h85EBCA77)};
  endfunction

  function automatic logic [W-1:0] pick(input logic [W-1:0] cur, input logic [W-1:0] prv, input int k);
    logic [2*W-1:0] both;
    both = {cur, prv};
    return both[k +: W];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rx_prev = '0; m_tx_prev = '0; m_off = '0; m_tamt = '0;
    m_req = 1'b0; m_err = 1'b0; m_gap = GAP;
  endtask

  task automatic step(input logic req, input logic [OW-1:0] ta, input string tag);
    logic [W-1:0] rd, td, e_rx, e_tx;
    @(negedge clk);
    rd = word_of(seq); td = word_of(seq + 7777); seq++;
    rx_data = rd; tx_data = td; rx_slip_req = req; tx_slip_amt = ta;
    e_rx = pick(rd, m_rx_prev, int'(m_off));
    e_tx = pick(td, m_tx_prev, int'(m_tamt));
    if (req && !m_req) begin
      if (m_gap >= GAP) begin
        m_off = (m_off == OW'(W - 1)) ? '0 : m_off + 1'b1;
        m_gap = 1;
      end else begin
        m_err = 1'b1;
        if (m_gap < GAP) m_gap++;
      end
    end else if (m_gap < GAP) m_gap++;
    m_req = req; m_tamt = ta; m_rx_prev = rd; m_tx_prev = td;
    @(posedge clk); #1;
    check({tag, " rx_out R4"}, rx_out, e_rx);
    check({tag, " rx_offset"}, W'(rx_offset), W'(m_off));
    check({tag, " rx_slip_err"}, W'(rx_slip_err), W'(m_err));
    check({tag, " tx_out R6"}, tx_out, e_tx);
    check({tag, " tx_offset R7"}, W'(tx_offset), W'(m_tamt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_slip_req = 1'b1; rx_data = word_of(99); tx_data = word_of(98); tx_slip_amt = 6'd9;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset rx_out", rx_out, '0);
    check("R8 reset tx_out", tx_out, '0);
    check("R8 reset offsets", W'({rx_offset, tx_offset}), '0);
    check("R8 reset err", W'(rx_slip_err), '0);
    @(negedge clk);
    rst_n = 1'b1; rx_slip_req = 1'b0; rx_data = '0; tx_data = '0; tx_slip_amt = '0;
    model_reset();
  endtask

  task automatic t_first_edge_and_early();
    do_reset();
    step(1'b1, '0, "R8 first edge");
    check("R1 offset after first edge", W'(rx_offset), W'(1));
    step(1'b0, '0, "R1");
    repeat (3) step(1'b0, '0, "R3 wait");
    step(1'b1, '0, "R3 early edge");
    check("R3 early edge ignored", W'(rx_offset), W'(1));
    check("R3 err set", W'(rx_slip_err), W'(1));
    repeat (14) step(1'b0, '0, "R3 wait");
    step(1'b1, '0, "R3 edge at exact gap");
    check("R3 accepted at gap", W'(rx_offset), W'(2));
    check("R3 err sticky", W'(rx_slip_err), W'(1));
  endtask

  task automatic t_held_level();
    do_reset();
    repeat (50) step(1'b1, '0, "R2 held high");
    check("R2 single slip for held level", W'(rx_offset), W'(1));
    check("R2 no error", W'(rx_slip_err), W'(0));
  endtask

  task automatic t_sweep_all_offsets();
    do_reset();
    for (int s = 0; s < W; s++) begin
      step(1'b1, '0, "R4 sweep");
      repeat (GAP - 1) step(1'b0, '0, "R4 sweep");
    end
    check("R5 wrapped to zero", W'(rx_offset), '0);
    check("R5 no error", W'(rx_slip_err), '0);
    step(1'b1, '0, "R5 after wrap");
    check("R5 slips again after wrap", W'(rx_offset), W'(1));
  endtask

  task automatic t_tx_amounts();
    do_reset();
    for (int a = 0; a < W; a++) step(1'b0, OW'(a), "R6 sweep");
    for (int a = 0; a < 20; a++) step(1'b0, OW'((a * 37) % W), "R7 jumps");
    step(1'b0, 6'd63, "R7");
    step(1'b0, 6'd0, "R7");
    check("R7 amount one word late", W'(tx_offset), '0);
  endtask

  initial begin
    model_reset();
    t_first_edge_and_early();
    t_held_level();
    t_sweep_all_offsets();
    t_tx_amounts();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule